// File: doc/BRIEF.md
# Two-Bank Byte-Addressed GPIO Controller

This block controls a set of general-purpose pins through a byte-wide register bus. The pins are split at a parameterised boundary into two banks. Pins below the boundary belong to the always-on core bank, and pins at or above it belong to the resume bank. Each bank has three register arrays with eight pins per byte: pin enable, pin direction and pin level. Software changes a single pin with a read-modify-write of the byte that holds it, because the block has no atomic bit set or clear.

The block drives an output value and an output-enable for every pin, and it samples every pin input through a synchronizer. For a pin set as an input, its level bit reports the synchronized pin state. Writes to that bit are discarded, so a level cannot be preset before the pin turns into an output. When the pin becomes an output, it drives whatever level its latch last held.

Top module: `gpio_dualwell`

## Requirements
- R1: Address bit 5 selects the bank (0 = core pins 0..SPLIT-1, 1 = resume pins SPLIT..PIN_CNT-1, indexed as pin minus SPLIT). Address bits 4:2 select the array (0 = enable, 1 = direction, 2 = level), so within a bank the enable array sits at +0x00, direction at +0x04 and level at +0x08. Bank-relative pin k lives in byte k/8 (address bits 1:0) at bit k mod 8.
- R2: While reset is asserted and afterwards until written, every direction bit is 1, every level latch is 0 and each enable bit equals bit p of the EN_RST parameter. As a result pin_oe and pin_out are all 0.
- R3: A pin drives (pin_oe = 1) only when its enable bit is 1 and its direction bit is 0 (output). A direction bit of 1 (input) forces pin_oe to 0.
- R4: An enable bit of 0 forces pin_oe of that pin to 0 whatever its direction bit holds.
- R5: A level write to a pin set as an output loads its latch. pin_out shows the latch, and a level read of an output pin returns the latch.
- R6: A level write to a pin set as an input is discarded. After that pin is switched to output, pin_out shows the latch value it held before the discarded write.
- R7: A level read of an input pin returns pin_in as it stood two clock edges earlier (two-flop synchronizer).
- R8: Reads return 0 for array codes 3..7, for byte indices at or beyond a bank's byte count, and for bits beyond a bank's pin count. Writes to those locations change no state.
- R9: A write takes effect at the rising clock edge on which bus_wr is sampled high. bus_rdata is a combinational function of bus_addr and the current state.
- R10: Enable and direction bits read back exactly the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address for both read and write |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr |
| pin_in | input | PIN_CNT | Sampled pin inputs |
| pin_out | output | PIN_CNT | Pin output values (level latches) |
| pin_oe | output | PIN_CNT | Pin output-enables |

## Verification
The properties assume that the bus address and write strobe are steady and known around each rising edge, and that pin 0 is in the core bank, so a write to address 0x00 or 0x04 always reaches it. The stimulus changes bus signals only on falling edges and keeps pin_in at 0 through reset. After each pin_in change it waits three edges before comparing level reads of input pins, except in the one directed case that measures the synchronizer delay edge by edge. Random addresses cover the whole 6-bit space on purpose, so writes to holes and to bits past the pin count are part of the normal traffic.

// File: rtl/gpio_dw_pkg.sv
package gpio_dw_pkg;
   localparam int ADDR_W        = 6;
   localparam int BANK_BIT      = 5;
   localparam int MAX_BANK_PINS = 32;
   localparam int BYTE_W        = 8;
   localparam int SEL_W         = 2;

   localparam logic [1:0] KIND_EN  = 2'd0;
   localparam logic [1:0] KIND_DIR = 2'd1;
   localparam logic [1:0] KIND_LVL = 2'd2;

   typedef struct packed {
      logic             hit;
      logic             bank;
      logic [1:0]       kind;
      logic [SEL_W-1:0] bsel;
   } dec_t;
endpackage

// File: rtl/gpio_dw_sync.sv
module gpio_dw_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[0] <= '0;
            else        stage[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_dw_decode.sv
module gpio_dw_decode
   import gpio_dw_pkg::*;
#(
   parameter int CORE_PINS = 10,
   parameter int RES_PINS  = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   localparam int CORE_BYTES = (CORE_PINS + BYTE_W - 1) / BYTE_W;
   localparam int RES_BYTES  = (RES_PINS + BYTE_W - 1) / BYTE_W;

   logic [2:0]       field;
   logic [SEL_W-1:0] bsel;
   logic             bank;
   logic             byte_ok;

   assign bank  = addr[BANK_BIT];
   assign field = addr[4:2];
   assign bsel  = addr[SEL_W-1:0];

   always_comb begin
      if (bank) byte_ok = int'(bsel) < RES_BYTES;
      else      byte_ok = int'(bsel) < CORE_BYTES;
   end

   assign dec.hit  = byte_ok && (field < 3'd3);
   assign dec.bank = bank;
   assign dec.kind = field[1:0];
   assign dec.bsel = bsel;
endmodule

// File: rtl/gpio_dw_bank.sv
module gpio_dw_bank
   import gpio_dw_pkg::*;
#(
   parameter int              NPIN   = 8,
   parameter logic [NPIN-1:0] EN_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [1:0]       kind,
   input  logic [SEL_W-1:0] bsel,
   input  logic [7:0]       wdata,
   input  logic [NPIN-1:0]  smp,
   output logic [NPIN-1:0]  lat,
   output logic [NPIN-1:0]  oe,
   output logic [7:0]       rdata
);
   logic [NPIN-1:0] en_q, dir_q, lat_q;

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      localparam int BI = i / BYTE_W;
      localparam int BB = i % BYTE_W;
      logic sel_b, en_b, dir_b, lat_b;

      assign sel_b = wr && (bsel == SEL_W'(BI));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_b  <= EN_RST[i];
            dir_b <= 1'b1;
            lat_b <= 1'b0;
         end else if (sel_b) begin
            case (kind)
               KIND_EN:  en_b  <= wdata[BB];
               KIND_DIR: dir_b <= wdata[BB];
               KIND_LVL: if (!dir_b) lat_b <= wdata[BB];
               default:  ;
            endcase
         end
      end

      assign en_q[i]  = en_b;
      assign dir_q[i] = dir_b;
      assign lat_q[i] = lat_b;
   end

   logic [NPIN-1:0]          lvl_view;
   logic [MAX_BANK_PINS-1:0] en_p, dir_p, lvl_p;
   logic [4:0]               base;

   assign lvl_view = (dir_q & smp) | (~dir_q & lat_q);
   assign en_p     = MAX_BANK_PINS'(en_q);
   assign dir_p    = MAX_BANK_PINS'(dir_q);
   assign lvl_p    = MAX_BANK_PINS'(lvl_view);
   assign base     = {bsel, 3'b000};

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (kind)
            KIND_EN:  rdata = en_p[base +: 8];
            KIND_DIR: rdata = dir_p[base +: 8];
            KIND_LVL: rdata = lvl_p[base +: 8];
            default:  rdata = '0;
         endcase
      end
   end

   assign lat = lat_q;
   assign oe  = en_q & ~dir_q;
endmodule

// File: rtl/gpio_dualwell.sv
module gpio_dualwell
   import gpio_dw_pkg::*;
#(
   parameter int                 PIN_CNT     = 14,
   parameter int                 SPLIT       = 10,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [PIN_CNT-1:0] EN_RST      = 14'h1C7F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [5:0]         bus_addr,
   input  logic               bus_wr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic [PIN_CNT-1:0] pin_in,
   output logic [PIN_CNT-1:0] pin_out,
   output logic [PIN_CNT-1:0] pin_oe
);
   localparam int RES_PINS = PIN_CNT - SPLIT;

   if (SPLIT < 1 || SPLIT > MAX_BANK_PINS || RES_PINS < 1 || RES_PINS > MAX_BANK_PINS)
   begin : g_bad_split
      $error("gpio_dualwell: each bank needs 1..32 pins");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_dualwell: SYNC_STAGES must be at least 2");
   end

   logic [PIN_CNT-1:0] smp;
   dec_t               dec;
   logic [7:0]         rd_core, rd_res;
   logic               wr_core, wr_res, rd_core_en, rd_res_en;

   gpio_dw_sync #(.W(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp)
   );

   gpio_dw_decode #(.CORE_PINS(SPLIT), .RES_PINS(RES_PINS)) u_dec (
      .addr(bus_addr), .dec(dec)
   );

   assign rd_core_en = dec.hit && !dec.bank;
   assign rd_res_en  = dec.hit &&  dec.bank;
   assign wr_core    = bus_wr && rd_core_en;
   assign wr_res     = bus_wr && rd_res_en;

   gpio_dw_bank #(.NPIN(SPLIT), .EN_RST(EN_RST[SPLIT-1:0])) u_core (
      .clk(clk), .rst_n(rst_n), .wr(wr_core), .rd(rd_core_en),
      .kind(dec.kind), .bsel(dec.bsel), .wdata(bus_wdata),
      .smp(smp[SPLIT-1:0]), .lat(pin_out[SPLIT-1:0]),
      .oe(pin_oe[SPLIT-1:0]), .rdata(rd_core)
   );

   gpio_dw_bank #(.NPIN(RES_PINS), .EN_RST(EN_RST[PIN_CNT-1:SPLIT])) u_res (
      .clk(clk), .rst_n(rst_n), .wr(wr_res), .rd(rd_res_en),
      .kind(dec.kind), .bsel(dec.bsel), .wdata(bus_wdata),
      .smp(smp[PIN_CNT-1:SPLIT]), .lat(pin_out[PIN_CNT-1:SPLIT]),
      .oe(pin_oe[PIN_CNT-1:SPLIT]), .rdata(rd_res)
   );

   assign bus_rdata = rd_core | rd_res;
endmodule

// File: rtl/gpio_dualwell_chk.sv
module gpio_dualwell_chk #(
   parameter int PIN_CNT = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic [5:0]         bus_addr,
   input logic               bus_wr,
   input logic [7:0]         bus_wdata,
   input logic [7:0]         bus_rdata,
   input logic [PIN_CNT-1:0] pin_out,
   input logic [PIN_CNT-1:0] pin_oe
);
   AST_RST_QUIET: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 && pin_out == '0));  // R2

   AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 6'h04 && bus_wdata == 8'hFF) |=> !pin_oe[0]);  // R3

   AST_DISABLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 6'h00 && !bus_wdata[0]) |=> !pin_oe[0]);  // R4

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr[4:2] == 3'd2) |=> $stable(pin_out));  // R6

   AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[4:2] > 3'd2) |-> (bus_rdata == 8'h00));  // R8
endmodule

bind gpio_dualwell gpio_dualwell_chk #(.PIN_CNT(PIN_CNT)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_gpio_dualwell.sv
module tb_gpio_dualwell;
   localparam int CLK_PERIOD = 10;
   localparam int PIN_CNT    = 14;
   localparam int SPLIT      = 10;
   localparam logic [PIN_CNT-1:0] EN_RST = 14'h1C7F;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [5:0]         bus_addr = '0;
   logic               bus_wr = 1'b0;
   logic [7:0]         bus_wdata = '0;
   logic [7:0]         bus_rdata;
   logic [PIN_CNT-1:0] pin_in = '0;
   logic [PIN_CNT-1:0] pin_out, pin_oe;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [PIN_CNT-1:0] en_m, dir_m, lat_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_dualwell #(.PIN_CNT(PIN_CNT), .SPLIT(SPLIT), .EN_RST(EN_RST)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int pin_of(logic [5:0] a, int b);
      int base = a[5] ? SPLIT : 0;
      int npin = a[5] ? PIN_CNT - SPLIT : SPLIT;
      int idx  = int'(a[1:0]) * 8 + b;
      if (a[4:2] > 3'd2 || idx >= npin) return -1;
      return base + idx;
   endfunction

   function automatic logic [7:0] exp_read(logic [5:0] a);
      logic [7:0] r = '0;
      for (int b = 0; b < 8; b++) begin
         int p = pin_of(a, b);
         if (p >= 0) begin
            case (a[4:2])
               3'd0: r[b] = en_m[p];
               3'd1: r[b] = dir_m[p];
               default: r[b] = dir_m[p] ? pin_in[p] : lat_m[p];
            endcase
         end
      end
      return r;
   endfunction

   function automatic void model_write(logic [5:0] a, logic [7:0] d);
      for (int b = 0; b < 8; b++) begin
         int p = pin_of(a, b);
         if (p >= 0) begin
            case (a[4:2])
               3'd0: en_m[p] = d[b];
               3'd1: dir_m[p] = d[b];
               default: if (!dir_m[p]) lat_m[p] = d[b];
            endcase
         end
      end
   endfunction

   task automatic wr(logic [5:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd_chk(string tag, logic [5:0] a);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, 32'(bus_rdata), 32'(exp_read(a)));
   endtask

   task automatic pins_chk(string tag);
      chk({tag, " pin_out"}, 32'(pin_out), 32'(lat_m));
      chk({tag, " pin_oe"}, 32'(pin_oe), 32'(en_m & ~dir_m));
   endtask

   task automatic set_in(logic [PIN_CNT-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      en_m = EN_RST; dir_m = '1; lat_m = '0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R2: reset state on the pins and in the registers
      pins_chk("R2 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      pins_chk("R2 after reset");
      @(negedge clk); bus_addr = 6'h00; #1;
      chk("R2 core enable byte0", 32'(bus_rdata), 32'h7F);
      bus_addr = 6'h01; #1;
      chk("R2 core enable byte1", 32'(bus_rdata), 32'h00);
      bus_addr = 6'h20; #1;
      chk("R2 resume enable byte0", 32'(bus_rdata), 32'h07);
      bus_addr = 6'h05; #1;
      chk("R2 core direction byte1", 32'(bus_rdata), 32'h03);
      bus_addr = 6'h24; #1;
      chk("R1 resume direction byte0", 32'(bus_rdata), 32'h0F);

      // R3: pins 0..7 to output, enabled ones drive
      wr(6'h04, 8'h00);
      pins_chk("R3 outputs");
      chk("R3 pin0 drives", 32'(pin_oe[0]), 32'h1);
      chk("R3 pin7 disabled", 32'(pin_oe[7]), 32'h0);
      // R4: disable pin 0
      wr(6'h00, 8'h7E);
      chk("R4 disabled pin0 released", 32'(pin_oe[0]), 32'h0);
      wr(6'h00, 8'h7F);

      // R5/R9: level write lands on the edge
      @(negedge clk);
      bus_addr = 6'h08; bus_wdata = 8'h01; bus_wr = 1'b1;
      #1;
      chk("R9 no change before edge", 32'(pin_out[0]), 32'h0);
      @(negedge clk);
      bus_wr = 1'b0; model_write(6'h08, 8'h01);
      chk("R5 pin0 level driven", 32'(pin_out[0]), 32'h1);
      rd_chk("R5 level readback", 6'h08);

      // R6: drop level write on input, then old level reappears
      wr(6'h04, 8'h01);
      wr(6'h08, 8'h00);
      chk("R6 latch kept", 32'(pin_out[0]), 32'h1);
      wr(6'h04, 8'h00);
      chk("R6 old level driven", 32'(pin_out[0]), 32'h1);
      chk("R6 pin0 drives", 32'(pin_oe[0]), 32'h1);

      // R7: synchronizer delay on pin 1 (input)
      wr(6'h04, 8'h02);
      @(negedge clk);
      pin_in[1] = 1'b1; bus_addr = 6'h08;
      @(negedge clk); #1;
      chk("R7 one edge later", 32'(bus_rdata[1]), 32'h0);
      @(negedge clk); #1;
      chk("R7 two edges later", 32'(bus_rdata[1]), 32'h1);
      set_in(pin_in);

      // R8: holes read zero, writes there ignored
      rd_chk("R8 core array code 3", 6'h0C);
      rd_chk("R8 core byte2", 6'h02);
      rd_chk("R8 resume byte1", 6'h21);
      wr(6'h1F, 8'hFF);
      wr(6'h3E, 8'hFF);
      wr(6'h01, 8'hFF);
      @(negedge clk); bus_addr = 6'h01; #1;
      chk("R8 bits past pin count", 32'(bus_rdata), 32'h03);
      // R10: enable and direction read back
      wr(6'h24, 8'h05);
      rd_chk("R10 resume direction", 6'h24);
      rd_chk("R10 core enable", 6'h00);
      pins_chk("R8 pins after hole writes");

      // random traffic (R1, R5, R6, R10)
      for (int it = 0; it < 4000; it++) begin
         int op = $urandom_range(0, 9);
         logic [5:0] a = 6'($urandom);
         if (op < 4) begin
            wr(a, 8'($urandom));
            pins_chk("R1 random pins");
         end else if (op < 9) begin
            rd_chk("R1 random read", a);
         end else begin
            set_in(PIN_CNT'($urandom));
            rd_chk("R7 random level", 6'h08);
            rd_chk("R7 random resume level", 6'h28);
         end
      end
      finish_run();
   end
endmodule